// File: doc/BRIEF.md
# Program Counter Load Unit

This block keeps a 13-bit program counter for a small instruction-sequencing core. Every clock it picks the next counter value from one of several sources: sequential increment, a computed write of the low byte, an absolute jump or call target, a popped return address, or a fixed interrupt vector. Instruction decode, the arithmetic unit and the return-address storage sit outside. They present their results on single-cycle strobes with data.

The upper counter bits are never written directly. A separate 5-bit upper-address latch, written over the 8-bit data bus, supplies them. A low-byte write copies all five latch bits into PC<12:8>. A jump or call copies only latch bits <4:3> into PC<12:11>, because its literal already covers PC<10:0>.

A computed branch writes the new low byte only. A carry out of the low byte is lost, so software must adjust the latch itself when a table crosses a 256-word page.

Top module: `pc_load_unit`

## Requirements
- R1: While `rst` is high, at each rising edge the counter and the latch become 0, and `pcOut`, `pcLowOut` and `latchOut` read 0.
- R2: With no load strobe active, the counter advances by one per clock and wraps from 0x1FFF to 0x0000.
- R3: A low-byte write sets the counter to {latch[4:0], lowWrData[7:0]}.
- R4: A jump/call sets the counter to {latch[4:3], jumpTarget[10:0]}.
- R5: A return sets the counter to `retAddr`.
- R6: An interrupt sets the counter to the fixed vector 0x0004.
- R7: When several strobes are active together, the winner is chosen in this order, highest first: interrupt, return, jump/call, low-byte write, increment.
- R8: A latch write stores `latchWrData[4:0]` and ignores bits 7:5. `latchOut` reads the stored 5 bits.
- R9: Only a latch write changes the latch. No counter load of any kind alters it.
- R10: PC<12:8> after a low-byte write comes from the latch alone. A low byte that wraps from 0xFF to 0x00 does not carry into the upper bits.
- R11: `pcLowOut` always equals `pcOut[7:0]`.
- R12: Every result appears at the first rising edge after its strobe. A load in the same cycle as a latch write uses the latch value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lowWrEn | input | 1 | Strobe: instruction result targets the low counter byte |
| lowWrData | input | 8 | Result written to the low byte |
| jumpEn | input | 1 | Strobe: jump or call |
| jumpTarget | input | 11 | Literal target from the instruction |
| retEn | input | 1 | Strobe: return of any kind |
| retAddr | input | 13 | Popped return address |
| irqEn | input | 1 | Strobe: branch to the interrupt vector |
| latchWrEn | input | 1 | Strobe: bus write to the upper-address latch |
| latchWrData | input | 8 | Bus data for the latch |
| pcOut | output | 13 | Current program counter |
| pcLowOut | output | 8 | Readable low byte of the counter |
| latchOut | output | 5 | Latch contents |

## Verification
Each strobe is sampled at one rising edge. Its effect on `pcOut`, `pcLowOut` and `latchOut` is visible straight after that edge, one cycle later. The bench drives strobes just after a falling edge and holds them for one full cycle. It then reads the outputs at the next falling edge, half a period after the updating edge.

Increment checks count one step per idle cycle from a known loaded value. Same-cycle tests compare against the latch value written before the strobe, because a write in that same cycle does not take effect until after the edge.

// File: rtl/pc_load_pkg.sv
package pc_load_pkg;
  // Next-value select handed from control to datapath; exactly one bit set
  typedef struct packed {
    logic vec;
    logic ret;
    logic jump;
    logic low;
    logic inc;
  } pcSel_t;
endpackage

// File: rtl/pc_load_ctrl.sv
module pc_load_ctrl
  import pc_load_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   irqEn,
  input  logic   retEn,
  input  logic   jumpEn,
  input  logic   lowWrEn,
  output pcSel_t sel
);
  // Fixed priority: interrupt > return > jump/call > low write > increment
  always_comb begin
    sel = '0;
    if (irqEn)        sel.vec  = 1'b1;
    else if (retEn)   sel.ret  = 1'b1;
    else if (jumpEn)  sel.jump = 1'b1;
    else if (lowWrEn) sel.low  = 1'b1;
    else              sel.inc  = 1'b1;
  end

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);
  assert_irq_wins_R7: assert property (@(posedge clk) disable iff (rst)
    irqEn |-> sel.vec);
  assert_ret_over_jump_R7: assert property (@(posedge clk) disable iff (rst)
    (retEn && !irqEn) |-> sel.ret);
  assert_jump_over_low_R7: assert property (@(posedge clk) disable iff (rst)
    (jumpEn && !retEn && !irqEn) |-> sel.jump);
  assert_idle_inc_R2: assert property (@(posedge clk) disable iff (rst)
    !(irqEn || retEn || jumpEn || lowWrEn) |-> sel.inc);
endmodule

// File: rtl/pc_load_dp.sv
module pc_load_dp
  import pc_load_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int LOW_W    = 8,
  parameter int LIT_W    = 11,
  parameter int LATCH_W  = 5,
  parameter logic [PC_W-1:0] VECTOR = 13'h0004
) (
  input  logic               clk,
  input  logic               rst,
  input  pcSel_t             sel,
  input  logic [LOW_W-1:0]   lowWrData,
  input  logic [LIT_W-1:0]   jumpTarget,
  input  logic [PC_W-1:0]    retAddr,
  input  logic               latchWrEn,
  input  logic [LOW_W-1:0]   latchWrData,
  output logic [PC_W-1:0]    pcQ,
  output logic [LATCH_W-1:0] latchQ
);
  localparam int HI_W  = PC_W - LOW_W;   // upper bits filled on low write
  localparam int JHI_W = PC_W - LIT_W;   // upper bits filled on jump/call

  logic [PC_W-1:0] pcNext;
  logic [PC_W-1:0] lowLoad;
  logic [PC_W-1:0] jumpLoad;

  assign lowLoad  = {latchQ[HI_W-1:0], lowWrData};
  assign jumpLoad = {latchQ[LATCH_W-1 -: JHI_W], jumpTarget};

  always_comb begin
    unique case (1'b1)
      sel.vec:  pcNext = VECTOR;
      sel.ret:  pcNext = retAddr;
      sel.jump: pcNext = jumpLoad;
      sel.low:  pcNext = lowLoad;
      default:  pcNext = pcQ + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (rst)            latchQ <= '0;
    else if (latchWrEn) latchQ <= latchWrData[LATCH_W-1:0];
  end

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (rst)
    sel.inc |=> pcQ == $past(pcQ) + 1'b1);
  assert_low_load_R3: assert property (@(posedge clk) disable iff (rst)
    sel.low |=> pcQ[LOW_W-1:0] == $past(lowWrData));
  assert_low_upper_R10: assert property (@(posedge clk) disable iff (rst)
    sel.low |=> pcQ[PC_W-1:LOW_W] == $past(latchQ[HI_W-1:0]));
  assert_jump_load_R4: assert property (@(posedge clk) disable iff (rst)
    sel.jump |=> pcQ == {$past(latchQ[LATCH_W-1 -: JHI_W]), $past(jumpTarget)});
  assert_ret_load_R5: assert property (@(posedge clk) disable iff (rst)
    sel.ret |=> pcQ == $past(retAddr));
  assert_vec_load_R6: assert property (@(posedge clk) disable iff (rst)
    sel.vec |=> pcQ == VECTOR);
  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !latchWrEn |=> $stable(latchQ));
  assert_latch_write_R8: assert property (@(posedge clk) disable iff (rst)
    latchWrEn |=> latchQ == $past(latchWrData[LATCH_W-1:0]));
endmodule

// File: rtl/pc_load_unit.sv
module pc_load_unit
  import pc_load_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LOW_W   = 8,
  parameter int LIT_W   = 11,
  parameter int LATCH_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lowWrEn,
  input  logic [LOW_W-1:0]   lowWrData,
  input  logic               jumpEn,
  input  logic [LIT_W-1:0]   jumpTarget,
  input  logic               retEn,
  input  logic [PC_W-1:0]    retAddr,
  input  logic               irqEn,
  input  logic               latchWrEn,
  input  logic [LOW_W-1:0]   latchWrData,
  output logic [PC_W-1:0]    pcOut,
  output logic [LOW_W-1:0]   pcLowOut,
  output logic [LATCH_W-1:0] latchOut
);
  pcSel_t sel;

  pc_load_ctrl ctrl_i (
    .clk(clk), .rst(rst), .irqEn(irqEn), .retEn(retEn),
    .jumpEn(jumpEn), .lowWrEn(lowWrEn), .sel(sel)
  );

  pc_load_dp #(.PC_W(PC_W), .LOW_W(LOW_W), .LIT_W(LIT_W), .LATCH_W(LATCH_W)) dp_i (
    .clk(clk), .rst(rst), .sel(sel), .lowWrData(lowWrData),
    .jumpTarget(jumpTarget), .retAddr(retAddr), .latchWrEn(latchWrEn),
    .latchWrData(latchWrData), .pcQ(pcOut), .latchQ(latchOut)
  );

  assign pcLowOut = pcOut[LOW_W-1:0];
endmodule

// File: tb/pc_load_unit_tb.sv
module pc_load_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lowWrEn = 1'b0;
  logic [7:0]  lowWrData = '0;
  logic        jumpEn = 1'b0;
  logic [10:0] jumpTarget = '0;
  logic        retEn = 1'b0;
  logic [12:0] retAddr = '0;
  logic        irqEn = 1'b0;
  logic        latchWrEn = 1'b0;
  logic [7:0]  latchWrData = '0;
  logic [12:0] pcOut;
  logic [7:0]  pcLowOut;
  logic [4:0]  latchOut;

  int checks = 0;
  int failures = 0;

  pc_load_unit dut_i (
    .clk(clk), .rst(rst), .lowWrEn(lowWrEn), .lowWrData(lowWrData),
    .jumpEn(jumpEn), .jumpTarget(jumpTarget), .retEn(retEn), .retAddr(retAddr),
    .irqEn(irqEn), .latchWrEn(latchWrEn), .latchWrData(latchWrData),
    .pcOut(pcOut), .pcLowOut(pcLowOut), .latchOut(latchOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Apply strobes for one cycle: outputs are read at the next falling edge
  task automatic cycle();
    @(negedge clk);
    lowWrEn = 0; jumpEn = 0; retEn = 0; irqEn = 0; latchWrEn = 0;
  endtask

  task automatic setLatch(input logic [7:0] v);
    latchWrEn = 1; latchWrData = v; cycle();
  endtask

  task automatic lowWrite(input logic [7:0] v);
    lowWrEn = 1; lowWrData = v; cycle();
  endtask

  task automatic test_reset();
    rst = 1; cycle(); cycle(); rst = 0;
    chk("R1 pc", pcOut, 13'h0);
    chk("R1 latch", {8'h0, latchOut}, 13'h0);
    chk("R1 low", {5'h0, pcLowOut}, 13'h0);
  endtask

  task automatic test_increment();
    cycle(); cycle(); cycle();   // released at the edge after rst low: 3 steps
    chk("R2 inc", pcOut, 13'h3);
  endtask

  task automatic test_latch();
    setLatch(8'h1A);
    chk("R8 latch", {8'h0, latchOut}, 13'h1A);
    setLatch(8'hF5);
    chk("R8 upper bits ignored", {8'h0, latchOut}, 13'h15);
  endtask

  task automatic test_lowWrite();
    lowWrite(8'h3C);
    chk("R3 low write", pcOut, 13'h153C);
    chk("R11 low byte", {5'h0, pcLowOut}, 13'h3C);
    chk("R9 latch after low write", {8'h0, latchOut}, 13'h15);
    cycle();
    chk("R2 inc after load", pcOut, 13'h153D);
    chk("R11 low byte", {5'h0, pcLowOut}, 13'h3D);
  endtask

  task automatic test_jump();
    jumpEn = 1; jumpTarget = 11'h123; cycle();
    chk("R4 jump", pcOut, 13'h1123);
    chk("R9 latch after jump", {8'h0, latchOut}, 13'h15);
  endtask

  task automatic test_pageWrap();
    setLatch(8'h02);
    lowWrite(8'hFF);
    chk("R3 low write", pcOut, 13'h02FF);
    lowWrite(8'h00);   // computed offset wrapped in the low byte
    chk("R10 no carry", pcOut, 13'h0200);
  endtask

  task automatic test_incWrap();
    setLatch(8'h1F);
    lowWrite(8'hFF);
    chk("R3 top", pcOut, 13'h1FFF);
    cycle();
    chk("R2 wrap", pcOut, 13'h0000);
  endtask

  task automatic test_retIrq();
    retEn = 1; retAddr = 13'h0ABC; cycle();
    chk("R5 return", pcOut, 13'h0ABC);
    chk("R9 latch after return", {8'h0, latchOut}, 13'h1F);
    irqEn = 1; cycle();
    chk("R6 vector", pcOut, 13'h0004);
    chk("R9 latch after irq", {8'h0, latchOut}, 13'h1F);
  endtask

  task automatic test_priority();
    irqEn = 1; retEn = 1; jumpEn = 1; lowWrEn = 1;
    retAddr = 13'h1234; jumpTarget = 11'h055; lowWrData = 8'h77; cycle();
    chk("R7 irq first", pcOut, 13'h0004);
    retEn = 1; jumpEn = 1; lowWrEn = 1; cycle();
    chk("R7 return second", pcOut, 13'h1234);
    jumpEn = 1; lowWrEn = 1; cycle();
    chk("R7 jump third", pcOut, 13'h1855);   // latch 0x1F -> bits 4:3 = 11
    lowWrEn = 1; cycle();
    chk("R7 low fourth", pcOut, 13'h1F77);
  endtask

  task automatic test_sameCycle();
    latchWrEn = 1; latchWrData = 8'h08; lowWrEn = 1; lowWrData = 8'h10; cycle();
    chk("R12 old latch used", pcOut, 13'h1F10);
    chk("R12 latch updated", {8'h0, latchOut}, 13'h08);
    lowWrite(8'h10);
    chk("R12 new latch next", pcOut, 13'h0810);
  endtask

  task automatic test_midReset();
    rst = 1; cycle(); rst = 0;
    chk("R1 pc mid-run", pcOut, 13'h0);
    chk("R1 latch mid-run", {8'h0, latchOut}, 13'h0);
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_increment();
    test_latch();
    test_lowWrite();
    test_jump();
    test_pageWrap();
    test_incWrap();
    test_retIrq();
    test_priority();
    test_sameCycle();
    test_midReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule